// File: doc/BRIEF.md
# RISC ALU with immediate handling

This block is the combinational execute stage of a 32-bit load/store RISC core. Each evaluation takes two register operands, a 16-bit immediate field, a 5-bit shift amount and an operation code. It returns a 32-bit result together with a zero flag and a signed-overflow flag. No clock or storage is involved: the outputs follow the inputs within the same cycle.

The second operand is either the register operand or the immediate. When the immediate is used, the operation decides how it is widened. Arithmetic and compare operations sign-extend it. Bitwise operations zero-extend it. The upper-constant operation places it in the high half of the result.

A single adder serves both the add/subtract operations and the magnitude compares. Logical shifts come from a shifter whose structure is selected by a parameter.

Top module: `risc_alu`

## Requirements
- R1: Codes 0 (add), 1 (add, unsigned variant), 2 (subtract) and 3 (subtract, unsigned variant) return src_a plus or minus src_b, modulo 2^32.
- R2: Codes 4, 5 and 6 return the bitwise AND, OR and XOR of src_a and src_b.
- R3: Codes 11 (add immediate) and 12 (add immediate, unsigned variant) add src_a to imm16 sign-extended to 32 bits. src_b has no effect on these codes.
- R4: Codes 15, 16 and 17 return src_a AND, OR and XOR imm16 zero-extended to 32 bits, so bits 31:16 of src_a pass through (OR, XOR) or are cleared (AND).
- R5: Codes 7 (left) and 8 (right) shift src_a logically by shamt, filling vacated bits with zeros. shamt has no effect on any other code.
- R6: Codes 9 (register) and 13 (immediate, sign-extended) return 32'd1 when src_a is less than the second operand as two's-complement signed values, and 32'd0 otherwise. This holds even when the difference overflows.
- R7: Codes 10 (register) and 14 (immediate, sign-extended) return 32'd1 when src_a is below the second operand as unsigned magnitudes, and 32'd0 otherwise.
- R8: Code 18 returns imm16 in bits 31:16 with bits 15:0 cleared, and src_a has no effect on it.
- R9: ovf_flag is 1 for codes 0, 2 and 11 when the operands' signs agree (add) or differ (subtract) and the result sign differs from src_a's sign.
- R10: ovf_flag is always 0 for codes 1, 3 and 12 and for every code that is not an add or subtract.
- R11: For every recognised code, zero_flag is 1 exactly when the 32-bit result is zero.
- R12: Any code from 19 to 31 yields a result of zero with zero_flag and ovf_flag both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | Result equals zero |
| ovf_flag | output | 1 | Signed add/subtract overflow |

## Verification
The zero flag and the overflow flag can both assert for the same operation. This happens when a signed add wraps exactly onto zero. The bench provokes it by adding 0x80000000 to itself with code 0, and expects a zero result with both flags high.

The same operands are then applied with subtract, code 2. There the result is zero but the overflow flag must stay low. Together these two cases show that the two flags are judged independently of each other.

// File: rtl/risc_alu_pkg.sv
package risc_alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD   = 5'd0,
      OP_ADDU  = 5'd1,
      OP_SUB   = 5'd2,
      OP_SUBU  = 5'd3,
      OP_AND   = 5'd4,
      OP_OR    = 5'd5,
      OP_XOR   = 5'd6,
      OP_SLL   = 5'd7,
      OP_SRL   = 5'd8,
      OP_SLT   = 5'd9,
      OP_SLTU  = 5'd10,
      OP_ADDI  = 5'd11,
      OP_ADDIU = 5'd12,
      OP_SLTI  = 5'd13,
      OP_SLTIU = 5'd14,
      OP_ANDI  = 5'd15,
      OP_ORI   = 5'd16,
      OP_XORI  = 5'd17,
      OP_LUI   = 5'd18
   } alu_op_e;

   typedef enum logic [1:0] {
      BSRC_REG  = 2'd0,
      BSRC_SEXT = 2'd1,
      BSRC_ZEXT = 2'd2
   } bsrc_e;

   typedef enum logic [2:0] {
      UNIT_NONE  = 3'd0,
      UNIT_ADD   = 3'd1,
      UNIT_CMP   = 3'd2,
      UNIT_LOGIC = 3'd3,
      UNIT_SHIFT = 3'd4,
      UNIT_UPPER = 3'd5
   } unit_e;

   typedef enum logic [1:0] {
      LFN_AND = 2'd0,
      LFN_OR  = 2'd1,
      LFN_XOR = 2'd2
   } logic_fn_e;

   typedef struct packed {
      logic      valid;
      unit_e     unit;
      bsrc_e     bsrc;
      logic      subtract;
      logic      signed_ovf;
      logic      cmp_signed;
      logic_fn_e lfn;
      logic      shift_right;
   } alu_ctrl_t;

   function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] op);
      alu_ctrl_t c;
      c.valid       = 1'b1;
      c.unit        = UNIT_NONE;
      c.bsrc        = BSRC_REG;
      c.subtract    = 1'b0;
      c.signed_ovf  = 1'b0;
      c.cmp_signed  = 1'b0;
      c.lfn         = LFN_AND;
      c.shift_right = 1'b0;
      case (op)
         OP_ADD:   begin c.unit = UNIT_ADD; c.signed_ovf = 1'b1; end
         OP_ADDU:  begin c.unit = UNIT_ADD; end
         OP_SUB:   begin c.unit = UNIT_ADD; c.subtract = 1'b1; c.signed_ovf = 1'b1; end
         OP_SUBU:  begin c.unit = UNIT_ADD; c.subtract = 1'b1; end
         OP_AND:   begin c.unit = UNIT_LOGIC; c.lfn = LFN_AND; end
         OP_OR:    begin c.unit = UNIT_LOGIC; c.lfn = LFN_OR; end
         OP_XOR:   begin c.unit = UNIT_LOGIC; c.lfn = LFN_XOR; end
         OP_SLL:   begin c.unit = UNIT_SHIFT; end
         OP_SRL:   begin c.unit = UNIT_SHIFT; c.shift_right = 1'b1; end
         OP_SLT:   begin c.unit = UNIT_CMP; c.subtract = 1'b1; c.cmp_signed = 1'b1; end
         OP_SLTU:  begin c.unit = UNIT_CMP; c.subtract = 1'b1; end
         OP_ADDI:  begin c.unit = UNIT_ADD; c.bsrc = BSRC_SEXT; c.signed_ovf = 1'b1; end
         OP_ADDIU: begin c.unit = UNIT_ADD; c.bsrc = BSRC_SEXT; end
         OP_SLTI:  begin c.unit = UNIT_CMP; c.bsrc = BSRC_SEXT; c.subtract = 1'b1;
                         c.cmp_signed = 1'b1; end
         OP_SLTIU: begin c.unit = UNIT_CMP; c.bsrc = BSRC_SEXT; c.subtract = 1'b1; end
         OP_ANDI:  begin c.unit = UNIT_LOGIC; c.bsrc = BSRC_ZEXT; c.lfn = LFN_AND; end
         OP_ORI:   begin c.unit = UNIT_LOGIC; c.bsrc = BSRC_ZEXT; c.lfn = LFN_OR; end
         OP_XORI:  begin c.unit = UNIT_LOGIC; c.bsrc = BSRC_ZEXT; c.lfn = LFN_XOR; end
         OP_LUI:   begin c.unit = UNIT_UPPER; end
         default:  begin c.valid = 1'b0; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/risc_alu_opnd.sv
module risc_alu_opnd
   import risc_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  bsrc_e             bsrc,
   input  logic [DATA_W-1:0] src_b,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] op_b
);

   localparam int EXT_W = DATA_W - IMM_W;

   generate
      if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm
         $error("risc_alu_opnd: IMM_W must be in 1..DATA_W-1");
      end
   endgenerate

   logic [DATA_W-1:0] imm_sext;
   logic [DATA_W-1:0] imm_zext;

   assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign imm_zext = {{EXT_W{1'b0}}, imm};

   always_comb begin
      case (bsrc)
         BSRC_SEXT: op_b = imm_sext;
         BSRC_ZEXT: op_b = imm_zext;
         default:   op_b = src_b;
      endcase
   end

endmodule

// File: rtl/risc_alu_arith.sv
module risc_alu_arith #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              subtract,
   input  logic              signed_ovf,
   input  logic              cmp_signed,
   output logic [DATA_W-1:0] sum,
   output logic              ovf,
   output logic              less
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;
   logic              sign_a;
   logic              sign_b;
   logic              sign_r;
   logic              raw_ovf;
   logic              less_u;
   logic              less_s;

   assign b_eff = subtract ? ~op_b : op_b;
   assign wide  = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, subtract};
   assign sum   = wide[MSB:0];

   assign sign_a = op_a[MSB];
   assign sign_b = op_b[MSB];
   assign sign_r = wide[MSB];

   // Add overflows when inputs agree in sign; subtract when they differ.
   assign raw_ovf = ((sign_a ~^ sign_b) ^ subtract) & (sign_r ^ sign_a);
   assign ovf     = signed_ovf & raw_ovf;

   // Carry out of a - b is clear exactly when a borrow occurred.
   assign less_u = ~wide[DATA_W];
   assign less_s = (sign_a ^ sign_b) ? sign_a : sign_r;
   assign less   = cmp_signed ? less_s : less_u;

endmodule

// File: rtl/risc_alu_logic.sv
module risc_alu_logic
   import risc_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter bit STAGED_SHIFT = 1'b1,
   localparam int SHAMT_W     = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0]  op_a,
   input  logic [DATA_W-1:0]  op_b,
   input  logic_fn_e          lfn,
   input  logic               shift_right,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [IMM_W-1:0]   imm,
   output logic [DATA_W-1:0]  logic_res,
   output logic [DATA_W-1:0]  shift_res,
   output logic [DATA_W-1:0]  upper_res
);

   localparam int LOW_W = DATA_W - IMM_W;

   always_comb begin
      case (lfn)
         LFN_OR:  logic_res = op_a | op_b;
         LFN_XOR: logic_res = op_a ^ op_b;
         default: logic_res = op_a & op_b;
      endcase
   end

   assign upper_res = {imm, {LOW_W{1'b0}}};

   generate
      if (STAGED_SHIFT) begin : g_staged
         logic [DATA_W-1:0] lstage [SHAMT_W+1];
         logic [DATA_W-1:0] rstage [SHAMT_W+1];
         assign lstage[0] = op_a;
         assign rstage[0] = op_a;
         for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
            assign lstage[s+1] = shamt[s] ? (lstage[s] << (1 << s)) : lstage[s];
            assign rstage[s+1] = shamt[s] ? (rstage[s] >> (1 << s)) : rstage[s];
         end
         assign shift_res = shift_right ? rstage[SHAMT_W] : lstage[SHAMT_W];
      end else begin : g_native
         assign shift_res = shift_right ? (op_a >> shamt) : (op_a << shamt);
      end
   endgenerate

endmodule

// File: rtl/risc_alu.sv
module risc_alu
   import risc_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter bit STAGED_SHIFT = 1'b1,
   localparam int SHAMT_W     = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]    op_sel,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   input  logic [IMM_W-1:0]   imm16,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DATA_W-1:0]  result,
   output logic               zero_flag,
   output logic               ovf_flag
);

   localparam int MSB = DATA_W - 1;

   generate
      if ((1 << SHAMT_W) != DATA_W) begin : g_bad_width
         $error("risc_alu: DATA_W must be a power of two");
      end
      if (2 * IMM_W > DATA_W) begin : g_bad_imm
         $error("risc_alu: IMM_W must not exceed half of DATA_W");
      end
   endgenerate

   alu_ctrl_t         ctrl;
   logic [DATA_W-1:0] op_b;
   logic [DATA_W-1:0] sum;
   logic              arith_ovf;
   logic              less;
   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] shift_res;
   logic [DATA_W-1:0] upper_res;

   always_comb ctrl = decode_op(op_sel);

   risc_alu_opnd #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_opnd (
      .bsrc  (ctrl.bsrc),
      .src_b (src_b),
      .imm   (imm16),
      .op_b  (op_b)
   );

   risc_alu_arith #(
      .DATA_W (DATA_W)
   ) u_arith (
      .op_a       (src_a),
      .op_b       (op_b),
      .subtract   (ctrl.subtract),
      .signed_ovf (ctrl.signed_ovf),
      .cmp_signed (ctrl.cmp_signed),
      .sum        (sum),
      .ovf        (arith_ovf),
      .less       (less)
   );

   risc_alu_logic #(
      .DATA_W       (DATA_W),
      .IMM_W        (IMM_W),
      .STAGED_SHIFT (STAGED_SHIFT)
   ) u_logic (
      .op_a        (src_a),
      .op_b        (op_b),
      .lfn         (ctrl.lfn),
      .shift_right (ctrl.shift_right),
      .shamt       (shamt),
      .imm         (imm16),
      .logic_res   (logic_res),
      .shift_res   (shift_res),
      .upper_res   (upper_res)
   );

   always_comb begin
      case (ctrl.unit)
         UNIT_ADD:   result = sum;
         UNIT_CMP:   result = {{(DATA_W-1){1'b0}}, less};
         UNIT_LOGIC: result = logic_res;
         UNIT_SHIFT: result = shift_res;
         UNIT_UPPER: result = upper_res;
         default:    result = '0;
      endcase
   end

   assign zero_flag = ctrl.valid & (result == '0);
   assign ovf_flag  = ctrl.valid & (ctrl.unit == UNIT_ADD) & arith_ovf;

   // Checks across the decode, operand and unit outputs
   always_comb begin
      if (!ctrl.valid) begin
         a_r12_invalid_quiet: assert (result == '0 && !zero_flag && !ovf_flag)
            else $error("R12: unrecognised code produced activity");
      end
      if (ctrl.unit == UNIT_CMP) begin
         a_r6_cmp_boolean: assert (result[MSB:1] == '0)
            else $error("R6: compare result not 0 or 1");
      end
      if (op_sel == OP_ADDU || op_sel == OP_SUBU || op_sel == OP_ADDIU
          || ctrl.unit != UNIT_ADD) begin
         a_r10_no_overflow: assert (!ovf_flag)
            else $error("R10: overflow raised on unflagged code");
      end
      if (ovf_flag) begin
         a_r9_ovf_sign_flip: assert (result[MSB] != src_a[MSB])
            else $error("R9: overflow without sign change");
      end
      if (op_sel == OP_LUI) begin
         a_r8_upper_place: assert (result[DATA_W-IMM_W-1:0] == '0
                                   && result[MSB:DATA_W-IMM_W] == imm16)
            else $error("R8: upper constant misplaced");
      end
      if (op_sel == OP_ORI) begin
         a_r4_ori_high_pass: assert (result[MSB:IMM_W] == src_a[MSB:IMM_W])
            else $error("R4: zero-extended OR altered high bits");
      end
   end

endmodule

// File: tb/risc_alu_bench.sv
module risc_alu_bench;

   localparam logic [4:0] C_ADD = 5'd0, C_ADDU = 5'd1, C_SUB = 5'd2, C_SUBU = 5'd3;
   localparam logic [4:0] C_AND = 5'd4, C_OR = 5'd5, C_XOR = 5'd6;
   localparam logic [4:0] C_SLL = 5'd7, C_SRL = 5'd8, C_SLT = 5'd9, C_SLTU = 5'd10;
   localparam logic [4:0] C_ADDI = 5'd11, C_ADDIU = 5'd12, C_SLTI = 5'd13, C_SLTIU = 5'd14;
   localparam logic [4:0] C_ANDI = 5'd15, C_ORI = 5'd16, C_XORI = 5'd17, C_LUI = 5'd18;

   logic        clk = 1'b0;
   logic [4:0]  op_sel = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [15:0] imm16 = '0;
   logic [4:0]  shamt = '0;
   logic [31:0] result;
   logic        zero_flag;
   logic        ovf_flag;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   risc_alu u_risc_alu (
      .op_sel    (op_sel),
      .src_a     (src_a),
      .src_b     (src_b),
      .imm16     (imm16),
      .shamt     (shamt),
      .result    (result),
      .zero_flag (zero_flag),
      .ovf_flag  (ovf_flag)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] imm, input logic [4:0] sh);
      @(posedge clk);
      op_sel = op; src_a = a; src_b = b; imm16 = imm; shamt = sh;
      @(negedge clk);
   endtask

   task automatic expect3(input string tag, input logic [31:0] r, input logic z, input logic v);
      check({tag, " result"}, result, r);
      check({tag, " zero"}, {31'd0, zero_flag}, {31'd0, z});
      check({tag, " ovf"}, {31'd0, ovf_flag}, {31'd0, v});
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      expect3("R11 idle add of zeros", 32'h0, 1'b1, 1'b0);
   endtask

   task automatic t_reg_arith;
      apply(C_ADD, 32'd5, 32'd7, 16'h0, 5'd0);                expect3("R1 add", 32'd12, 1'b0, 1'b0);
      apply(C_ADDU, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);       expect3("R1 addu wrap", 32'h0, 1'b1, 1'b0);
      apply(C_SUB, 32'd3, 32'd5, 16'h0, 5'd0);                expect3("R1 sub", 32'hFFFF_FFFE, 1'b0, 1'b0);
      apply(C_SUBU, 32'd0, 32'd1, 16'h0, 5'd0);               expect3("R1 subu", 32'hFFFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_reg_logic;
      apply(C_AND, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0); expect3("R2 and", 32'h00F0_1200, 1'b0, 1'b0);
      apply(C_OR,  32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0); expect3("R2 or",  32'hFFF0_FF34, 1'b0, 1'b0);
      apply(C_XOR, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0); expect3("R2 xor", 32'hFF00_ED34, 1'b0, 1'b0);
      apply(C_XOR, 32'h1234_5678, 32'h1234_5678, 16'h0, 5'd0); expect3("R2 xor self R11", 32'h0, 1'b1, 1'b0);
   endtask

   task automatic t_imm_ext;
      apply(C_ADDI, 32'd10, 32'hDEAD_BEEF, 16'hFFFE, 5'd0);  expect3("R3 addi neg", 32'd8, 1'b0, 1'b0);
      apply(C_ADDIU, 32'd0, 32'hDEAD_BEEF, 16'h8000, 5'd0);  expect3("R3 addiu sext", 32'hFFFF_8000, 1'b0, 1'b0);
      apply(C_ANDI, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 16'h8001, 5'd0); expect3("R4 andi", 32'h0000_8001, 1'b0, 1'b0);
      apply(C_ORI, 32'h1234_0000, 32'h0, 16'hFFFF, 5'd0);   expect3("R4 ori", 32'h1234_FFFF, 1'b0, 1'b0);
      apply(C_XORI, 32'hFFFF_0000, 32'h0, 16'h8000, 5'd0);  expect3("R4 xori", 32'hFFFF_8000, 1'b0, 1'b0);
   endtask

   task automatic t_shift;
      apply(C_SLL, 32'h1, 32'h0, 16'h0, 5'd31);             expect3("R5 sll 31", 32'h8000_0000, 1'b0, 1'b0);
      apply(C_SRL, 32'h8000_0000, 32'h0, 16'h0, 5'd31);     expect3("R5 srl 31", 32'h1, 1'b0, 1'b0);
      apply(C_SRL, 32'hF000_000F, 32'h0, 16'h0, 5'd4);      expect3("R5 srl zero fill", 32'h0F00_0000, 1'b0, 1'b0);
      apply(C_SLL, 32'h0000_ABCD, 32'h0, 16'h0, 5'd0);      expect3("R5 sll 0", 32'h0000_ABCD, 1'b0, 1'b0);
      apply(C_SLL, 32'h8000_0001, 32'h0, 16'h0, 5'd1);      expect3("R5 sll drop", 32'h2, 1'b0, 1'b0);
      apply(C_ADD, 32'd1, 32'd2, 16'h0, 5'd31);             expect3("R5 shamt ignored", 32'd3, 1'b0, 1'b0);
   endtask

   task automatic t_compare;
      apply(C_SLT, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);      expect3("R6 slt -1<1", 32'd1, 1'b0, 1'b0);
      apply(C_SLT, 32'd1, 32'hFFFF_FFFF, 16'h0, 5'd0);      expect3("R6 slt 1<-1", 32'd0, 1'b1, 1'b0);
      apply(C_SLT, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0); expect3("R6 slt wrap R10", 32'd1, 1'b0, 1'b0);
      apply(C_SLT, 32'd42, 32'd42, 16'h0, 5'd0);            expect3("R6 slt equal", 32'd0, 1'b1, 1'b0);
      apply(C_SLTI, 32'hFFFF_FFFB, 32'h0, 16'hFFFC, 5'd0);  expect3("R6 slti -5<-4", 32'd1, 1'b0, 1'b0);
      apply(C_SLTU, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);     expect3("R7 sltu big", 32'd0, 1'b1, 1'b0);
      apply(C_SLTU, 32'd1, 32'hFFFF_FFFF, 16'h0, 5'd0);     expect3("R7 sltu small", 32'd1, 1'b0, 1'b0);
      apply(C_SLTIU, 32'd5, 32'h0, 16'hFFFF, 5'd0);         expect3("R7 sltiu sext", 32'd1, 1'b0, 1'b0);
   endtask

   task automatic t_upper;
      apply(C_LUI, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hABCD, 5'd3); expect3("R8 lui", 32'hABCD_0000, 1'b0, 1'b0);
      apply(C_LUI, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0);      expect3("R8 lui zero R11", 32'h0, 1'b1, 1'b0);
   endtask

   task automatic t_overflow;
      apply(C_ADD, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);      expect3("R9 add ovf", 32'h8000_0000, 1'b0, 1'b1);
      apply(C_SUB, 32'h8000_0000, 32'd1, 16'h0, 5'd0);      expect3("R9 sub ovf", 32'h7FFF_FFFF, 1'b0, 1'b1);
      apply(C_SUB, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 5'd0); expect3("R9 sub neg ovf", 32'h8000_0000, 1'b0, 1'b1);
      apply(C_ADDI, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);  expect3("R9 addi ovf", 32'h7FFF_FFFF, 1'b0, 1'b1);
      apply(C_ADD, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);      expect3("R9 add no ovf", 32'h0, 1'b1, 1'b0);
      apply(C_ADDU, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);     expect3("R10 addu", 32'h8000_0000, 1'b0, 1'b0);
      apply(C_SUBU, 32'h8000_0000, 32'd1, 16'h0, 5'd0);     expect3("R10 subu", 32'h7FFF_FFFF, 1'b0, 1'b0);
      apply(C_ADDIU, 32'h7FFF_FFFF, 32'h0, 16'h0001, 5'd0); expect3("R10 addiu", 32'h8000_0000, 1'b0, 1'b0);
   endtask

   task automatic t_zero_and_ovf;
      apply(C_ADD, 32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0); expect3("R9 R11 wrap to zero", 32'h0, 1'b1, 1'b1);
      apply(C_SUB, 32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0); expect3("R11 sub to zero", 32'h0, 1'b1, 1'b0);
   endtask

   task automatic t_invalid;
      apply(5'd19, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd31); expect3("R12 code 19", 32'h0, 1'b0, 1'b0);
      apply(5'd31, 32'h7FFF_FFFF, 32'd1, 16'h1234, 5'd4);          expect3("R12 code 31", 32'h0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_reg_arith();
      t_reg_logic();
      t_imm_ext();
      t_shift();
      t_compare();
      t_upper();
      t_overflow();
      t_zero_and_ovf();
      t_invalid();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule